// File: doc/BRIEF.md
# I2C Bus-Clear Recovery Sequencer

This block frees an I2C bus that a slave is holding because a transfer was cut off part-way. On a start request it first gives the bus controller a bounded window for its busy flag to fall. It then looks at the data line through a synchronizer. If the controller still reports busy, or the data line is low, the sequencer takes the clock pin away from the controller and drives it as a plain output. It clocks the stuck slave until the slave lets the data line go, or until a fixed number of pulses has been issued.

The sequence always ends with the clock driven high for one phase. After that the pins go back to the controller. A single-cycle done pulse marks the end of every run, including runs that needed no recovery. A status flag tells whether the data line was still low when the run finished. All time intervals are parameters in clock cycles, so a 1 ms phase and a one-second busy window become plain cycle counts.

Top module: `i2c_bus_unstick`

## Requirements
- R1: While reset is high and in the first cycle after it, `scl_drive_o` is 1, `pin_own_o` is 0, `done_o` is 0 and `sda_stuck_o` is 0.
- R2: `start_i` is acted on only while the sequencer is idle. A start pulse during a run neither restarts nor lengthens the run, and it produces no extra done pulse.
- R3: After a start, the sequencer waits while `busy_i` is 1 for at most WAIT_POLLS*POLL_CYCLES cycles. With busy held high the whole time, `pin_own_o` rises on the (WAIT_POLLS*POLL_CYCLES+2)-th rising edge counted from the edge that sampled the start.
- R4: After the wait, recovery begins only if `busy_i` is still 1 or the synchronized data line is 0. Otherwise the run ends without taking the pins.
- R5: Recovery begins by driving the clock low (`scl_drive_o`=0) for PHASE_CYCLES cycles, and `pin_own_o` is 1 from the first low cycle.
- R6: At the end of each low phase, if the synchronized data line is 0 and fewer than MAX_PULSES high phases have been issued, the clock is driven high for PHASE_CYCLES and then low for PHASE_CYCLES. A data line read as 1 at that point ends the pulsing early.
- R7: No more than MAX_PULSES clock high phases precede the final high phase, so one run shows at most MAX_PULSES+1 rising clock edges while the pins are owned.
- R8: After pulsing, the clock is driven high for one final PHASE_CYCLES interval. Then `pin_own_o` returns to 0, and `scl_drive_o` stays 1 whenever the pins are not owned.
- R9: Every run ends with `done_o` high for exactly one cycle, with `pin_own_o` already 0 in that cycle.
- R10: `sda_stuck_o` takes the value "synchronized data line is 0" at the end of the final high phase. It is cleared when a new run is accepted and is 0 after a run that needed no recovery.
- R11: The data line passes through a two-flop synchronizer before any decision. A low level that first appears one cycle before the post-wait decision edge is not seen by that decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a bus-clear run; sampled only while idle |
| busy_i | input | 1 | Busy indication from the I2C controller |
| sda_i | input | 1 | Raw level of the data pin |
| scl_drive_o | output | 1 | Level driven onto the clock pin while owned (1 = released high) |
| pin_own_o | output | 1 | 1 = pins under sequencer control, 0 = pins under controller |
| done_o | output | 1 | One-cycle pulse at the end of each run |
| sda_stuck_o | output | 1 | Data line still low at the end of the last run |

## Verification
The assertions assume that `busy_i` and `start_i` come from logic in the same clock domain and are stable at the clock edge. The only asynchronous input is `sda_i`, and it is allowed to change at any cycle. The bench drives every input on the falling edge. It holds the data line low from a slave model that lets go after a chosen number of rising clock edges, or never. The cap, early-stop, timeout and synchronizer-latency cases therefore all arise from legal input behaviour, and a reference model of the phase timing is compared with the outputs on every cycle.

// File: rtl/unstick_pkg.sv
package unstick_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_DECIDE,
    ST_LOW,
    ST_HIGH,
    ST_FINAL,
    ST_DONE
  } seq_state_t;

endpackage

// File: rtl/unstick_sync.sv
module unstick_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= RST_VAL;
        else     chain_q <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RST_VAL}};
        else     chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/unstick_timer.sv
module unstick_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic         hit
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  // hit marks the last cycle of an interval of `limit` cycles
  assign hit = (cnt_q == limit - 1'b1);

endmodule

// File: rtl/i2c_bus_unstick.sv
module i2c_bus_unstick #(
  parameter int PHASE_CYCLES = 50000,
  parameter int POLL_CYCLES  = 50000,
  parameter int WAIT_POLLS   = 1000,
  parameter int MAX_PULSES   = 10,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic busy_i,
  input  logic sda_i,
  output logic scl_drive_o,
  output logic pin_own_o,
  output logic done_o,
  output logic sda_stuck_o
);
  import unstick_pkg::*;

  localparam int WAIT_CYCLES = POLL_CYCLES * WAIT_POLLS;
  localparam int TMAX        = (WAIT_CYCLES > PHASE_CYCLES) ? WAIT_CYCLES : PHASE_CYCLES;
  localparam int TW          = $clog2(TMAX + 1);
  localparam int PW          = $clog2(MAX_PULSES + 1);
  localparam logic [TW-1:0] LIM_WAIT  = TW'(WAIT_CYCLES);
  localparam logic [TW-1:0] LIM_PHASE = TW'(PHASE_CYCLES);
  localparam logic [PW-1:0] PULSE_CAP = PW'(MAX_PULSES);

  seq_state_t    state_q, state_d;
  logic [PW-1:0] pulses_q;
  logic          sda_s;
  logic          tmr_hit;
  logic          tmr_clr;
  logic [TW-1:0] tmr_limit;
  logic          scl_q, own_q, done_q, stuck_q;

  unstick_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
    .clk (clk),
    .rst (rst),
    .d   (sda_i),
    .q   (sda_s)
  );

  assign tmr_limit = (state_q == ST_WAIT) ? LIM_WAIT : LIM_PHASE;
  assign tmr_clr   = (state_d != state_q);

  unstick_timer #(.W(TW)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clr   (tmr_clr),
    .limit (tmr_limit),
    .hit   (tmr_hit)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_WAIT;
      ST_WAIT:   if (!busy_i || tmr_hit) state_d = ST_DECIDE;
      ST_DECIDE: state_d = (busy_i || !sda_s) ? ST_LOW : ST_DONE;
      ST_LOW: begin
        if (tmr_hit) begin
          if (!sda_s && (pulses_q < PULSE_CAP)) state_d = ST_HIGH;
          else                                  state_d = ST_FINAL;
        end
      end
      ST_HIGH:   if (tmr_hit) state_d = ST_LOW;
      ST_FINAL:  if (tmr_hit) state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      pulses_q <= '0;
      scl_q    <= 1'b1;
      own_q    <= 1'b0;
      done_q   <= 1'b0;
      stuck_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      scl_q   <= (state_d != ST_LOW);
      own_q   <= (state_d == ST_LOW) || (state_d == ST_HIGH) || (state_d == ST_FINAL);
      done_q  <= (state_d == ST_DONE);
      if (state_q == ST_DECIDE)
        pulses_q <= '0;
      else if ((state_q == ST_LOW) && (state_d == ST_HIGH))
        pulses_q <= pulses_q + 1'b1;
      if ((state_q == ST_IDLE) && start_i)
        stuck_q <= 1'b0;
      else if ((state_q == ST_FINAL) && tmr_hit)
        stuck_q <= !sda_s;
    end
  end

  assign scl_drive_o = scl_q;
  assign pin_own_o   = own_q;
  assign done_o      = done_q;
  assign sda_stuck_o = stuck_q;

endmodule

// File: rtl/unstick_checks.sv
module unstick_checks #(
  parameter int MAX_PULSES = 10
) (
  input logic clk,
  input logic rst,
  input logic scl,
  input logic own,
  input logic done,
  input logic stuck
);

  logic       scl_prev;
  logic [7:0] rises;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_prev <= 1'b1;
      rises    <= '0;
    end else begin
      scl_prev <= scl;
      if (!own)                rises <= '0;
      else if (scl && !scl_prev) rises <= rises + 1'b1;
    end
  end

  // R8: clock released high whenever the pins belong to the controller
  a_r8_scl_high_unowned: assert property (@(posedge clk) disable iff (rst)
    !own |-> scl);

  // R5: the first owned cycle drives the clock low
  a_r5_first_phase_low: assert property (@(posedge clk) disable iff (rst)
    $rose(own) |-> !scl);

  // R9: done lasts exactly one cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: pins handed back before done is raised
  a_r9_done_unowned: assert property (@(posedge clk) disable iff (rst)
    done |-> !own);

  // R7: clock rising edges per run never exceed the cap plus the final high
  a_r7_pulse_cap: assert property (@(posedge clk) disable iff (rst)
    rises <= 8'(MAX_PULSES + 1));

  // R10: the status flag only changes on the done edge or when it is cleared
  a_r10_stuck_moves_at_end: assert property (@(posedge clk) disable iff (rst)
    $rose(stuck) |-> done);

endmodule

bind i2c_bus_unstick unstick_checks #(.MAX_PULSES(MAX_PULSES)) u_checks (
  .clk   (clk),
  .rst   (rst),
  .scl   (scl_drive_o),
  .own   (pin_own_o),
  .done  (done_o),
  .stuck (sda_stuck_o)
);

// File: tb/i2c_bus_unstick_tb.sv
module i2c_bus_unstick_tb;

  localparam int CLK_PERIOD = 10;
  localparam int PHASE      = 4;
  localparam int POLL       = 3;
  localparam int POLLS      = 4;
  localparam int WAITC      = POLL * POLLS;
  localparam int MAXP       = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic busy = 1'b0;
  logic sda_low_req = 1'b0;
  int   release_at = -1;
  logic sda;
  logic scl, own, done, stuck;

  int vec = 0;
  int miss = 0;
  int rises = 0;
  int dones = 0;
  logic scl_seen = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  // slave model: holds the data line low until a chosen number of clock rises
  assign sda = !(sda_low_req && ((release_at < 0) || (rises < release_at)));

  i2c_bus_unstick #(
    .PHASE_CYCLES (PHASE),
    .POLL_CYCLES  (POLL),
    .WAIT_POLLS   (POLLS),
    .MAX_PULSES   (MAXP),
    .SYNC_STAGES  (2)
  ) u_dut (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start),
    .busy_i      (busy),
    .sda_i       (sda),
    .scl_drive_o (scl),
    .pin_own_o   (own),
    .done_o      (done),
    .sda_stuck_o (stuck)
  );

  // behavioural reference: phase number, elapsed cycles, pulses, delayed data
  int m_ph = 0, m_cnt = 0, m_pul = 0, m_stuck = 0;
  int m_d1 = 1, m_d2 = 1;

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_cnt = 0; m_pul = 0; m_stuck = 0; m_d1 = 1; m_d2 = 1;
    end else begin
      case (m_ph)
        0: if (start) begin m_ph = 1; m_cnt = 0; m_stuck = 0; end
        1: if (!busy || m_cnt == WAITC - 1) begin m_ph = 2; m_cnt = 0; end
           else m_cnt++;
        2: begin
             if (busy || m_d2 == 0) begin m_ph = 3; m_pul = 0; end
             else m_ph = 6;
             m_cnt = 0;
           end
        3: if (m_cnt == PHASE - 1) begin
             m_cnt = 0;
             if (m_d2 == 0 && m_pul < MAXP) begin m_ph = 4; m_pul++; end
             else m_ph = 5;
           end else m_cnt++;
        4: if (m_cnt == PHASE - 1) begin m_cnt = 0; m_ph = 3; end
           else m_cnt++;
        5: if (m_cnt == PHASE - 1) begin
             m_cnt = 0; m_ph = 6; m_stuck = (m_d2 == 0) ? 1 : 0;
           end else m_cnt++;
        default: m_ph = 0;
      endcase
      m_d2 = m_d1;
      m_d1 = sda ? 1 : 0;
    end
  end

  // per-cycle comparison and event monitor, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      int e_scl, e_own, e_done;
      e_scl  = (m_ph == 3) ? 0 : 1;
      e_own  = (m_ph >= 3 && m_ph <= 5) ? 1 : 0;
      e_done = (m_ph == 6) ? 1 : 0;
      vec++;
      if (scl !== e_scl[0] || own !== e_own[0]) begin
        miss++;
        if (m_ph == 3)      $display("FAIL R5 scl/own act=%b/%b exp=%0d/%0d", scl, own, e_scl, e_own);
        else if (m_ph == 4) $display("FAIL R6 scl/own act=%b/%b exp=%0d/%0d", scl, own, e_scl, e_own);
        else if (m_ph == 5) $display("FAIL R8 scl/own act=%b/%b exp=%0d/%0d", scl, own, e_scl, e_own);
        else                $display("FAIL R4 scl/own act=%b/%b exp=%0d/%0d", scl, own, e_scl, e_own);
      end
      if (done !== e_done[0]) begin
        miss++;
        $display("FAIL R9 done act=%b exp=%0d", done, e_done);
      end
      if (stuck !== m_stuck[0]) begin
        miss++;
        $display("FAIL R10 stuck act=%b exp=%0d", stuck, m_stuck);
      end
      if (own && scl && !scl_seen) rises++;
      if (done) dones++;
      scl_seen = scl;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    vec++;
    if (act != exp) begin
      miss++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(input int limit);
    for (int k = 0; k < limit; k++) begin
      @(negedge clk);
      if (done) break;
    end
    @(negedge clk);
  endtask

  initial begin
    int r0, d0, k, owned;
    repeat (3) @(negedge clk);
    chk("R1 scl in reset", int'(scl), 1);
    chk("R1 own in reset", int'(own), 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 outputs after reset", int'({scl, own, done, stuck}), 8);

    // clean bus: no recovery, done only
    r0 = rises; d0 = dones;
    pulse_start();
    wait_done(100);
    chk("R4 no rises on clean bus", rises - r0, 0);
    chk("R9 one done on clean bus", dones - d0, 1);
    chk("R10 stuck clear on clean bus", int'(stuck), 0);

    // data held low forever: cap reached
    sda_low_req = 1'b1; release_at = -1;
    r0 = rises; d0 = dones;
    pulse_start();
    wait_done(500);
    chk("R7 rises at cap", rises - r0, MAXP + 1);
    chk("R10 stuck after capped run", int'(stuck), 1);
    chk("R9 one done after capped run", dones - d0, 1);
    sda_low_req = 1'b0;
    repeat (4) @(negedge clk);

    // slave lets go after three rises: early stop
    r0 = rises;
    release_at = r0 + 3; sda_low_req = 1'b1;
    pulse_start();
    wait_done(500);
    chk("R6 early stop rises", rises - r0, 4);
    chk("R10 stuck after released run", int'(stuck), 0);
    sda_low_req = 1'b0; release_at = -1;
    repeat (4) @(negedge clk);

    // busy never drops: timeout, then one low phase and the final high
    busy = 1'b1;
    r0 = rises;
    @(negedge clk); start = 1'b1;
    k = 0;
    for (int n = 0; n < 200; n++) begin
      @(negedge clk); start = 1'b0; k++;
      if (own) break;
    end
    chk("R3 edges from start to ownership", k, WAITC + 2);
    wait_done(200);
    chk("R8 busy-only run rises", rises - r0, 1);
    busy = 1'b0;
    repeat (4) @(negedge clk);

    // low level arriving one cycle before the decision edge is not seen
    owned = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; sda_low_req = 1'b1;
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      if (own) owned = 1;
    end
    chk("R11 late low not seen by decision", owned, 0);
    sda_low_req = 1'b0;
    repeat (4) @(negedge clk);

    // second start during a run is ignored
    d0 = dones;
    release_at = rises + 2; sda_low_req = 1'b1;
    pulse_start();
    repeat (20) @(negedge clk);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (150) @(negedge clk);
    chk("R2 single done with start mid-run", dones - d0, 1);
    chk("R2 idle after run", int'(own), 0);
    sda_low_req = 1'b0; release_at = -1;

    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miss++;
    $display("FAIL watchdog expired act=hung exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end

endmodule